// File: doc/BRIEF.md
# Looping Sideband Command Sequencer

This block runs a small table of commands, one after another, on an 8-bit sideband bus. That bus shares the clock of the main peripheral bus, but its cycles do not depend on main-bus traffic. Software fills the table and sets the loop length while the sequencer is stopped. It then raises `run_en`, and the sequencer repeats the table with no further help. Each command does one of four things. It samples a FIFO-status byte from a MAC into a per-device register, sends a flow-control byte to a MAC, reads a byte from a peer device, or writes the last peer-read byte back out to a peer.

Every command takes exactly three clocks, with the controller states named as follows:
- **ADDR**: device select and payload are placed on the bus.
- **DATA**: the data byte is transferred.
- **RECOV**: the bus is quiet.

The controller has four states: IDLE, ADDR, DATA and RECOV. Its transitions are:
- IDLE→ADDR when `run_en` is high.
- ADDR→DATA and DATA→RECOV always.
- RECOV→ADDR when `run_en` is still high. The sequencer moves to the next entry, wrapping to entry 0 after the last one.
- RECOV→IDLE when `run_en` is low. The entry index returns to 0.

A stop request therefore never cuts a bus cycle short.

Top module: `sbseq_loop`

## Requirements
- R1: After reset the sequencer is in IDLE. `busy`, `sb_frame`, `sb_dphase` and `sb_oe` are 0. `sb_sel`, `sb_dout`, all status bytes and `peer_q` are 0. The loop length is 12.
- R2: A command word is decoded as follows:
  - bits [15:14] are the opcode: 00 status sample, 01 flow control, 10 peer read, 11 peer write.
  - bits [13:11] are the device select.
  - bits [7:0] are the payload.
  - bits [10:8] have no effect.
- R3: Every command lasts three clocks:
  - ADDR: `sb_frame`=1, `sb_dphase`=0, `sb_oe`=1, `sb_sel`=device, `sb_dout`=payload.
  - DATA: `sb_frame`=1, `sb_dphase`=1, `sb_sel`=device.
  - RECOV: `sb_frame`, `sb_dphase`, `sb_oe`, `sb_sel` and `sb_dout` are all 0.
- R4: In the DATA clock of a status sample, `sb_oe`=0 and `sb_dout`=0. `sb_din` is stored into the status byte of the selected device (`stat_flat[8*d+7:8*d]`) at the edge that ends DATA. The other devices' bytes are unchanged.
- R5: In the DATA clock of a flow-control command, `sb_oe`=1 and `sb_dout` carries the payload.
- R6: A peer read stores `sb_din` into `peer_q` at the edge that ends DATA, with `sb_oe`=0 during DATA. A peer write drives the current `peer_q` on `sb_dout` with `sb_oe`=1 during DATA.
- R7: While `run_en` stays high, the entry after entry length−1 is entry 0. No IDLE clock falls between commands.
- R8: When `run_en` is low at the end of RECOV, the sequencer goes to IDLE and `busy` falls. The next start begins at entry 0.
- R9: Table and length writes are ignored while `busy` is 1. A length outside 1..12 is ignored. A table address of 12 or more is ignored.
- R10: From IDLE with `run_en`=1, the next clock is ADDR of entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the main bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run request; low asks for a stop after the current command |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry index |
| tbl_data | input | 16 | Command word to store |
| len_we | input | 1 | Loop-length write strobe |
| len_val | input | 4 | New loop length (1..12) |
| busy | output | 1 | Sequencer is not in IDLE |
| sb_frame | output | 1 | Address or data phase in progress |
| sb_dphase | output | 1 | Data phase in progress |
| sb_sel | output | 3 | Device select |
| sb_dout | output | 8 | Sideband data driven by the block |
| sb_oe | output | 1 | Driver enable for `sb_dout` |
| sb_din | input | 8 | Sideband data received from devices |
| stat_flat | output | 64 | Eight sampled status bytes, device d at bits [8d+7:8d] |
| peer_q | output | 8 | Last byte read from a peer |

## Verification
The assertions assume that `sb_din` is driven whenever a DATA clock ends, because it is captured there. They also assume that `run_en`, the write strobes and their data are synchronous to `clk` and never unknown after reset. The bench changes every input only on the falling edge. It keeps `sb_din` at a defined, changing value on every clock, so a capture in the wrong clock yields a different byte. Writes are attempted both in IDLE and in the middle of a running loop, together with lengths of 0, 13, 1 and 12, so that ignored writes stay inside the protocol the checker relies on.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;
    localparam int SB_DW  = 8;
    localparam int SEL_W  = 3;
    localparam int RSV_W  = 3;
    localparam int CMD_W  = 2 + SEL_W + RSV_W + SB_DW;
    localparam int NDEV   = 1 << SEL_W;

    typedef enum logic [1:0] {
        OP_SAMPLE  = 2'b00,
        OP_FLOW    = 2'b01,
        OP_PEER_RD = 2'b10,
        OP_PEER_WR = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_RECOV = 2'd3
    } state_e;

    typedef struct packed {
        op_e              op;
        logic [SEL_W-1:0] dev;
        logic [RSV_W-1:0] rsvd;
        logic [SB_DW-1:0] payload;
    } cmd_t;
endpackage

// File: rtl/sbseq_table.sv
module sbseq_table
    import sbseq_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_addr,
    input  cmd_t             tbl_data,
    input  logic             len_we,
    input  logic [IDX_W-1:0] len_val,
    input  logic [IDX_W-1:0] rd_idx,
    output cmd_t             rd_cmd,
    output logic [IDX_W-1:0] len
);
    localparam logic [IDX_W-1:0] MAX_LEN = IDX_W'(DEPTH);

    cmd_t entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_ok && tbl_we && tbl_addr == IDX_W'(g))
                entry_q[g] <= tbl_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len <= MAX_LEN;
        else if (wr_ok && len_we && len_val != '0 && len_val <= MAX_LEN)
            len <= len_val;
    end

    always_comb begin
        rd_cmd = '0;
        if (rd_idx < MAX_LEN)
            rd_cmd = entry_q[rd_idx];
    end
endmodule

// File: rtl/sbseq_fsm.sv
module sbseq_fsm
    import sbseq_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [IDX_W-1:0] len,
    output state_e           state,
    output logic [IDX_W-1:0] pc
);
    state_e           state_nxt;
    logic [IDX_W-1:0] pc_nxt;
    logic             at_last;

    assign at_last = (pc == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
        end else begin
            state <= state_nxt;
            pc    <= pc_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        pc_nxt    = pc;
        unique case (state)
            ST_IDLE: begin
                pc_nxt = '0;
                if (run_en)
                    state_nxt = ST_ADDR;
            end
            ST_ADDR:  state_nxt = ST_DATA;
            ST_DATA:  state_nxt = ST_RECOV;
            ST_RECOV: begin
                if (run_en) begin
                    state_nxt = ST_ADDR;
                    pc_nxt    = at_last ? '0 : pc + 1'b1;
                end else begin
                    state_nxt = ST_IDLE;
                    pc_nxt    = '0;
                end
            end
        endcase
    end
endmodule

// File: rtl/sbseq_stat.sv
module sbseq_stat
    import sbseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_stat,
    input  logic [SEL_W-1:0]   cap_dev,
    input  logic               cap_peer,
    input  logic [SB_DW-1:0]   din,
    output logic [NDEV*SB_DW-1:0] stat_flat,
    output logic [SB_DW-1:0]   peer_q
);
    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        logic [SB_DW-1:0] stat_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_q <= '0;
            else if (cap_stat && cap_dev == SEL_W'(g))
                stat_q <= din;
        end
        assign stat_flat[g*SB_DW +: SB_DW] = stat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            peer_q <= '0;
        else if (cap_peer)
            peer_q <= din;
    end
endmodule

// File: rtl/sbseq_loop.sv
module sbseq_loop
    import sbseq_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic                  tbl_we,
    input  logic [IDX_W-1:0]      tbl_addr,
    input  logic [CMD_W-1:0]      tbl_data,
    input  logic                  len_we,
    input  logic [IDX_W-1:0]      len_val,
    output logic                  busy,
    output logic                  sb_frame,
    output logic                  sb_dphase,
    output logic [SEL_W-1:0]      sb_sel,
    output logic [SB_DW-1:0]      sb_dout,
    output logic                  sb_oe,
    input  logic [SB_DW-1:0]      sb_din,
    output logic [NDEV*SB_DW-1:0] stat_flat,
    output logic [SB_DW-1:0]      peer_q
);
    state_e           state;
    logic [IDX_W-1:0] pc;
    logic [IDX_W-1:0] len;
    cmd_t             cmd;

    sbseq_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (state == ST_IDLE),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_data (cmd_t'(tbl_data)),
        .len_we   (len_we),
        .len_val  (len_val),
        .rd_idx   (pc),
        .rd_cmd   (cmd),
        .len      (len)
    );

    sbseq_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .len    (len),
        .state  (state),
        .pc     (pc)
    );

    sbseq_stat u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stat  (state == ST_DATA && cmd.op == OP_SAMPLE),
        .cap_dev   (cmd.dev),
        .cap_peer  (state == ST_DATA && cmd.op == OP_PEER_RD),
        .din       (sb_din),
        .stat_flat (stat_flat),
        .peer_q    (peer_q)
    );

    always_comb begin
        busy      = 1'b1;
        sb_frame  = 1'b0;
        sb_dphase = 1'b0;
        sb_sel    = '0;
        sb_dout   = '0;
        sb_oe     = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_ADDR: begin
                sb_frame = 1'b1;
                sb_sel   = cmd.dev;
                sb_dout  = cmd.payload;
                sb_oe    = 1'b1;
            end
            ST_DATA: begin
                sb_frame  = 1'b1;
                sb_dphase = 1'b1;
                sb_sel    = cmd.dev;
                if (cmd.op == OP_FLOW) begin
                    sb_dout = cmd.payload;
                    sb_oe   = 1'b1;
                end else if (cmd.op == OP_PEER_WR) begin
                    sb_dout = peer_q;
                    sb_oe   = 1'b1;
                end
            end
            ST_RECOV: ;
        endcase
    end
endmodule

// File: rtl/sbseq_chk.sv
module sbseq_chk
    import sbseq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run_en,
    input logic                  busy,
    input logic                  sb_frame,
    input logic                  sb_dphase,
    input logic [SEL_W-1:0]      sb_sel,
    input logic [SB_DW-1:0]      sb_dout,
    input logic                  sb_oe,
    input logic [NDEV*SB_DW-1:0] stat_flat,
    input logic [SB_DW-1:0]      peer_q
);
    AST_DPHASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sb_dphase |-> sb_frame);  // R3
    AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_frame && !sb_dphase) |=> (sb_frame && sb_dphase));  // R3
    AST_DATA_THEN_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        sb_dphase |=> (busy && !sb_frame));  // R3
    AST_ADDR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_frame && !sb_dphase) |-> sb_oe);  // R3
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sb_dphase |-> $stable(sb_sel));  // R3
    AST_RECOV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sb_frame) |-> (!sb_oe && sb_dout == '0 && sb_sel == '0));  // R3
    AST_STAT_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_dphase |=> $stable(stat_flat));  // R4
    AST_PEER_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_dphase |=> $stable(peer_q));  // R6
    AST_LOOP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sb_frame && run_en) |=> (sb_frame && !sb_dphase));  // R7
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sb_frame && !run_en) |=> !busy);  // R8
    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_en) |=> (sb_frame && !sb_dphase));  // R10
endmodule

bind sbseq_loop sbseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .busy      (busy),
    .sb_frame  (sb_frame),
    .sb_dphase (sb_dphase),
    .sb_sel    (sb_sel),
    .sb_dout   (sb_dout),
    .sb_oe     (sb_oe),
    .stat_flat (stat_flat),
    .peer_q    (peer_q)
);

// File: tb/tb_sbseq_loop.sv
module tb_sbseq_loop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        len_we = 1'b0;
    logic [3:0]  len_val = '0;
    logic        busy, sb_frame, sb_dphase, sb_oe;
    logic [2:0]  sb_sel;
    logic [7:0]  sb_dout;
    logic [7:0]  sb_din = 8'h5A;
    logic [63:0] stat_flat;
    logic [7:0]  peer_q;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // behavioural reference state
    int mtab [12];
    int mstat [8];
    int mlen = 12, mph = 0, mpc = 0, mpeer = 0;

    sbseq_loop dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .len_we(len_we), .len_val(len_val),
        .busy(busy), .sb_frame(sb_frame), .sb_dphase(sb_dphase),
        .sb_sel(sb_sel), .sb_dout(sb_dout), .sb_oe(sb_oe),
        .sb_din(sb_din), .stat_flat(stat_flat), .peer_q(peer_q)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int op, input int dev, input int rsv, input int pay);
        return 16'((op << 14) | (dev << 11) | (rsv << 8) | (pay & 255));
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 12; i++) mtab[i] = 0;
        for (int d = 0; d < 8; d++) mstat[d] = 0;
        mlen = 12; mph = 0; mpc = 0; mpeer = 0;
    endfunction

    initial model_reset();

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) model_reset();
        else begin
            int op, dev;
            op  = (mtab[mpc] >> 14) & 3;
            dev = (mtab[mpc] >> 11) & 7;
            case (mph)
                0: begin
                    if (tbl_we && int'(tbl_addr) < 12) mtab[int'(tbl_addr)] = int'(tbl_data);
                    if (len_we && int'(len_val) >= 1 && int'(len_val) <= 12) mlen = int'(len_val);
                    if (run_en) mph = 1;
                end
                1: mph = 2;
                2: begin
                    if (op == 0) mstat[dev] = int'(sb_din);
                    if (op == 2) mpeer = int'(sb_din);
                    mph = 3;
                end
                default: begin
                    if (run_en) begin
                        mph = 1;
                        mpc = (mpc + 1 >= mlen) ? 0 : mpc + 1;
                    end else begin
                        mph = 0;
                        mpc = 0;
                    end
                end
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int op, dev, pay, efr, edp, esel, eoe, edo;
            longint est;
            op  = (mtab[mpc] >> 14) & 3;
            dev = (mtab[mpc] >> 11) & 7;
            pay = mtab[mpc] & 255;
            efr = (mph == 1 || mph == 2) ? 1 : 0;
            edp = (mph == 2) ? 1 : 0;
            esel = efr ? dev : 0;
            eoe = (mph == 1 || (mph == 2 && (op == 1 || op == 3))) ? 1 : 0;
            edo = (mph == 1) ? pay :
                  (mph == 2 && op == 1) ? pay :
                  (mph == 2 && op == 3) ? mpeer : 0;
            est = 0;
            for (int d = 0; d < 8; d++) est |= longint'(mstat[d]) << (8 * d);
            chk(int'(sb_frame) == efr, "R3 frame", longint'(sb_frame), efr);
            chk(int'(sb_dphase) == edp, "R3 dphase", longint'(sb_dphase), edp);
            chk(int'(sb_sel) == esel, "R2 select", longint'(sb_sel), esel);
            chk(int'(sb_oe) == eoe, "R5 R6 oe", longint'(sb_oe), eoe);
            chk(int'(sb_dout) == edo, "R5 R6 R9 dout", longint'(sb_dout), edo);
            chk(int'(busy) == ((mph != 0) ? 1 : 0), "R7 R8 busy", longint'(busy), (mph != 0) ? 1 : 0);
            chk(longint'(stat_flat) == est, "R4 status", longint'(stat_flat), est);
            chk(int'(peer_q) == mpeer, "R6 peer", longint'(peer_q), mpeer);
        end
    end

    always @(negedge clk) sb_din <= sb_din + 8'd53;

    task automatic wr_tbl(input int a, input logic [15:0] d);
        @(negedge clk); tbl_we = 1'b1; tbl_addr = 4'(a); tbl_data = d;
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic wr_len(input int l);
        @(negedge clk); len_we = 1'b1; len_val = 4'(l);
        @(negedge clk); len_we = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk); run_en = 1'b1;
        @(negedge clk);
        chk(sb_frame && !sb_dphase, "R10 start enters address phase", longint'(sb_frame), 1);
    endtask

    task automatic stop_run();
        do @(negedge clk); while (!(sb_frame && !sb_dphase));
        run_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(busy == 1'b1, "R8 recovery completes", longint'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle after stop", longint'(busy), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !sb_frame && !sb_oe && sb_dout == 8'h00, "R1 idle outputs", longint'(busy), 0);
        chk(stat_flat == 64'h0 && peer_q == 8'h00, "R1 cleared status", longint'(stat_flat), 0);

        wr_tbl(0, mk(0, 2, 7, 8'h11));   // sample, reserved bits set (R2)
        wr_tbl(1, mk(1, 5, 0, 8'hA5));   // flow control
        wr_tbl(2, mk(2, 7, 0, 8'h3C));   // peer read
        wr_tbl(3, mk(3, 1, 5, 8'h40));   // peer write
        wr_tbl(4, mk(0, 0, 0, 8'h22));
        wr_tbl(5, mk(0, 7, 0, 8'h33));
        wr_tbl(13, mk(1, 3, 0, 8'hEE));  // R9 out-of-range address
        wr_len(5);
        start_run();
        idle(40);
        // R9 writes while running are ignored
        @(negedge clk); tbl_we = 1'b1; tbl_addr = 4'd0; tbl_data = mk(1, 6, 0, 8'h99);
        len_we = 1'b1; len_val = 4'd2;
        @(negedge clk); tbl_we = 1'b0; len_we = 1'b0;
        idle(30);
        stop_run();

        wr_len(0);   // R9 ignored
        wr_len(13);  // R9 ignored
        start_run();
        idle(20);
        stop_run();

        for (int i = 6; i < 12; i++) wr_tbl(i, mk(i & 3, (i * 3) & 7, 0, 16 * i + 1));
        wr_len(12);
        start_run();
        idle(80);
        stop_run();

        wr_len(1);   // R7 single-entry loop
        start_run();
        idle(15);
        stop_run();
        idle(4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule